// File: doc/BRIEF.md
# Fixed-Phase Oversampled Bit Slicer

This block sits after a frequency discriminator that delivers four signed samples for every transmitted symbol, one bit per symbol. It counts the valid samples it receives modulo four and, on the sample whose index within the symbol matches a static two-bit phase setting, takes the sign of that sample as the hard bit decision. A non-negative sample gives a one and a negative sample gives a zero. The decided bit leaves with a one-clock valid pulse.

Alongside the decisions the block drives a monitor stream at the full sample rate. Each sample carries a two-bit signed code of +1 or -1 that shows the most recent decision, so the monitor trace can be laid over the discriminator output when the phase setting is being tuned. The phase setting is chosen from outside for synchronisation. It is not recovered from the data. A new setting is taken up only at a symbol boundary, so every symbol yields exactly one decision. Decisions made before the first real symbol reaches the input are not suppressed, and the logic downstream must skip them.

Top module: `bit_slicer`

## Requirements
- R1: After reset `bitValid` and `monitorValid` are low and `bitOut` is 0. The next valid sample has in-symbol index 0.
- R2: The decided bit is 1 when the chosen sample is zero or positive, and 0 when it is negative (two's complement sign bit).
- R3: Every valid sample advances the in-symbol index 0,1,2,3,0,... `bitValid` is high for exactly the one clock after a valid sample whose index equals the active phase setting, and `bitOut` carries the decision during that clock.
- R4: A cycle with `sampleValid` low leaves the index unchanged. In the next clock `bitValid` and `monitorValid` are low.
- R5: `monitorValid` is high for the one clock after each valid sample. `monitorOut` is then 2'b01 (+1) when the latest decision, including one made on that sample, is 1, and 2'b11 (-1) when it is 0 or when no decision has been made yet.
- R6: Until the first valid sample after reset, the active phase follows `phaseSel` directly. After that, `phaseSel` is captured only on a valid sample with index 3 and governs the symbols that follow.
- R7: While `phaseSel` changes, each group of four valid samples still produces exactly one decision: none is repeated and none is dropped.
- R8: `bitOut` holds its value in every clock in which `bitValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | SAMPLE_W | Signed discriminator sample |
| sampleValid | input | 1 | Sample qualifier |
| phaseSel | input | PHASE_W | Requested sampling phase, 0 to 3 |
| bitOut | output | 1 | Hard bit decision |
| bitValid | output | 1 | One-clock pulse marking a decision |
| monitorOut | output | 2 | Signed ±1 code of the latest decision |
| monitorValid | output | 1 | Marks a monitor code, one per valid sample |

## Verification
Alternating-sign and pseudo-random sample streams are run at every fixed phase setting. Because only one sample in four decides the bit, a wrong phase or a shifted index shows up at once in the decided values. Samples of exactly zero and the most negative value probe the sign rule at its edge. Gaps of invalid cycles placed inside symbols show whether the index stalls and whether the outputs stay quiet during the gap. The phase setting is changed at each position inside a symbol, including before the first sample. Each decision is then compared with a behavioural model, and the number of decisions is checked against the symbol count, which exposes both repeated and skipped symbols.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  // strobes from the phase control to the decision datapath
  typedef struct packed {
    logic advance;  // a valid sample is present this cycle
    logic take;     // this sample is the chosen phase of its symbol
    logic wrap;     // this sample closes a symbol
  } slicer_strobe_t;

  localparam logic [1:0] MON_POS = 2'b01;
  localparam logic [1:0] MON_NEG = 2'b11;
endpackage

// File: rtl/slicer_ctrl.sv
module slicer_ctrl
  import slicer_pkg::*;
#(
  parameter int OSR     = 4,
  parameter int PHASE_W = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [PHASE_W-1:0] phaseSel,
  output slicer_strobe_t     strobe
);
  localparam logic [PHASE_W-1:0] LAST_IDX = PHASE_W'(OSR - 1);

  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] activeOffset;
  logic [PHASE_W-1:0] effOffset;
  logic               started;

  // before any sample the requested phase is used directly
  assign effOffset = started ? activeOffset : phaseSel;

  always_comb begin
    strobe.advance = sampleValid;
    strobe.take    = sampleValid && (phaseCnt == effOffset);
    strobe.wrap    = sampleValid && (phaseCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt     <= '0;
      activeOffset <= '0;
      started      <= 1'b0;
    end else begin
      if (strobe.advance) begin
        phaseCnt <= strobe.wrap ? '0 : phaseCnt + 1'b1;
        started  <= 1'b1;
      end
      // new phase takes effect only at a symbol boundary
      if (!started || strobe.wrap) activeOffset <= phaseSel;
    end
  end
endmodule

// File: rtl/slicer_dp.sv
module slicer_dp
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  slicer_strobe_t      strobe,
  output logic                bitOut,
  output logic                bitValid,
  output logic [1:0]          monitorOut,
  output logic                monitorValid
);
  logic decision;
  logic heldBit;
  logic nextHeld;

  // sign decides: non-negative gives one
  assign decision = ~sampleIn[SAMPLE_W-1];
  assign nextHeld = strobe.take ? decision : heldBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitOut       <= 1'b0;
      bitValid     <= 1'b0;
      heldBit      <= 1'b0;
      monitorOut   <= MON_NEG;
      monitorValid <= 1'b0;
    end else begin
      bitValid     <= strobe.take;
      monitorValid <= strobe.advance;
      if (strobe.take) begin
        bitOut  <= decision;
        heldBit <= decision;
      end
      if (strobe.advance) monitorOut <= nextHeld ? MON_POS : MON_NEG;
    end
  end
endmodule

// File: rtl/bit_slicer.sv
module bit_slicer
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int OSR      = 4,
  parameter int PHASE_W  = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [PHASE_W-1:0]  phaseSel,
  output logic                bitOut,
  output logic                bitValid,
  output logic [1:0]          monitorOut,
  output logic                monitorValid
);
  slicer_strobe_t strobe;

  slicer_ctrl #(.OSR(OSR), .PHASE_W(PHASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .phaseSel(phaseSel), .strobe(strobe)
  );

  slicer_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobe(strobe),
    .bitOut(bitOut), .bitValid(bitValid),
    .monitorOut(monitorOut), .monitorValid(monitorValid)
  );
endmodule

// File: rtl/slicer_chk.sv
module slicer_chk #(
  parameter int SAMPLE_W = 10,
  parameter int OSR      = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic                bitOut,
  input logic                bitValid,
  input logic [1:0]          monitorOut,
  input logic                monitorValid
);
  localparam int GAP_W = $clog2(2 * OSR + 1) + 1;

  logic [GAP_W-1:0] sinceBit;
  logic             seenBit;

  // counts monitor events without a decision since the last decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceBit <= '0;
      seenBit  <= 1'b0;
    end else if (bitValid) begin
      sinceBit <= '0;
      seenBit  <= 1'b1;
    end else if (monitorValid && sinceBit < GAP_W'(2 * OSR)) begin
      sinceBit <= sinceBit + 1'b1;
    end
  end

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> (!bitValid && !monitorValid));

  a_r3_bit_with_monitor: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> monitorValid);

  a_r2_sign_rule: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (bitOut == !$past(sampleIn[SAMPLE_W-1])));

  a_r5_monitor_code: assert property (@(posedge clk) disable iff (!rstN)
    monitorValid |-> (monitorOut == 2'b01 || monitorOut == 2'b11));

  a_r5_monitor_follows: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (monitorOut == (bitOut ? 2'b01 : 2'b11)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitOut));

  a_r7_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    seenBit |-> (sinceBit <= GAP_W'(2 * OSR - 2)));
endmodule

bind bit_slicer slicer_chk #(.SAMPLE_W(SAMPLE_W), .OSR(OSR)) u_chk (
  .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
  .bitOut(bitOut), .bitValid(bitValid),
  .monitorOut(monitorOut), .monitorValid(monitorValid)
);

// File: tb/sim_bit_slicer.sv
module sim_bit_slicer;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          sampleValid = 1'b0;
  logic [1:0]    phaseSel = 2'd0;
  logic          bitOut, bitValid, monitorValid;
  logic [1:0]    monitorOut;

  int checks = 0, fails = 0, cycles = 0;

  // behavioural model state
  int  validCount = 0;
  int  activeOff = 0;
  bit  started = 0;
  bit  held = 0;
  bit  lastBit = 0;
  int  decisions = 0;
  int  validTotal = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_slicer #(.SAMPLE_W(SW), .OSR(4)) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .phaseSel(phaseSel), .bitOut(bitOut), .bitValid(bitValid),
    .monitorOut(monitorOut), .monitorValid(monitorValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // one clock: drive at negedge, predict, compare after the edge
  task automatic step(input int value, input bit valid, input int off);
    bit expBv, expMv, pick;
    int eff, idx;
    logic [1:0] expMon;
    @(negedge clk);
    sampleIn = SW'(value);
    sampleValid = valid;
    phaseSel = 2'(off);
    eff = started ? activeOff : off;
    if (!started) activeOff = off;
    expBv = 0; expMv = 0;
    if (valid) begin
      idx = validCount % 4;
      pick = (idx == eff);
      if (pick) begin
        lastBit = (value >= 0);
        held = lastBit;
        expBv = 1;
        decisions++;
      end
      expMv = 1;
      if (idx == 3) activeOff = off;
      validCount++;
      validTotal++;
      started = 1;
    end
    expMon = held ? 2'b01 : 2'b11;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(bitValid == expBv, valid ? "R3 bitValid" : "R4 bitValid idle", bitValid, expBv);
    check(monitorValid == expMv, valid ? "R5 monitorValid" : "R4 monitorValid idle",
          monitorValid, expMv);
    check(bitOut == lastBit, expBv ? "R2 bitOut" : "R8 bitOut hold", bitOut, lastBit);
    if (expMv) check(monitorOut == expMon, "R5 monitorOut", monitorOut, expMon);
  endtask

  task automatic do_reset(input int off);
    @(negedge clk);
    rstN = 0; sampleValid = 0; phaseSel = 2'(off);
    validCount = 0; activeOff = 0; started = 0; held = 0; lastBit = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(bitValid == 0, "R1 bitValid", bitValid, 0);
    check(monitorValid == 0, "R1 monitorValid", monitorValid, 0);
    check(bitOut == 0, "R1 bitOut", bitOut, 0);
  endtask

  initial begin
    int lfsr;
    int v;
    lfsr = 32'h1ace;
    // fixed phases, alternating-sign symbols
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(ph);
      for (int s = 0; s < 24; s++)
        for (int k = 0; k < 4; k++)
          step(((s + k) % 2 == 0) ? 100 + k : -90 - k, 1, ph);
    end
    // boundary values R2: zero gives one, most negative gives zero
    do_reset(1);
    for (int s = 0; s < 12; s++)
      for (int k = 0; k < 4; k++)
        step((s % 2 == 0) ? 0 : -(1 << (SW-1)), 1, 1);
    step(-1, 1, 1); step(0, 1, 1); step(-1, 1, 1); step(-1, 1, 1);
    // pseudo-random with invalid gaps R4
    do_reset(2);
    for (int n = 0; n < 600; n++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      v = (lfsr >>> 8) % 512 - 256;
      step(v, ((lfsr >>> 3) % 4) != 0, 2);
    end
    // offset changes at every position R6 R7
    do_reset(0);
    decisions = 0; validTotal = 0;
    step(50, 0, 3);      // R6 before first sample follows input
    for (int n = 0; n < 800; n++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      v = (lfsr >>> 8) % 512 - 256;
      step(v, ((lfsr >>> 4) % 5) != 0, (n / 3 + n / 7) % 4);
    end
    while (validTotal % 4 != 0) step(7, 1, 0);
    step(0, 0, 0);
    // R7 exactly one decision per symbol (first symbol already counted)
    check(decisions == validTotal / 4, "R7 decisions per symbol", decisions, validTotal / 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule